// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This block turns an instruction's addressing fields into the value the datapath needs: either the effective address of the operand or, for the modes that carry the operand directly, the operand itself. A request presents a mode code, an address field A, a register index R, the current program counter and an indirection depth code. The block reads register R from an external register file, forms a first result with one adder, and when the mode needs memory it walks a chain of pointers through a synchronous read port, one outstanding read at a time.

Indexing and indirection can be combined in either order. One mode adds the index before the pointer is fetched, the other fetches the pointer and adds the index to the word returned. The indexed mode also writes R+1 back into the register file. When the request is complete the block raises a one-cycle done strobe, holds the result and reports how many memory reads the request cost.

Top module: `ea_unit`

## Requirements
- R1: Mode code 0 (immediate) returns A unchanged and issues no memory read (mem_count 0).
- R2: Mode code 1 (direct) returns A with no memory read; codes 10 to 15 are reserved and behave exactly as code 1.
- R3: Mode code 2 (indirect) with depth code d follows d+1 pointer levels starting at address A and returns the last word read; mem_count equals d+1.
- R4: Mode code 3 (register) and mode code 4 (register-indirect) both return the contents of register R with no memory read; in code 4 that value is the effective address.
- R5: Mode code 5 returns A + reg[R] and mode code 6 returns A + PC, both modulo 2^AW with no memory read.
- R6: Mode code 7 (indexed) returns A + reg[R] and writes reg[R]+1 (modulo 2^AW) back to register R; no other mode writes the register file.
- R7: Mode code 8 (preindexed) returns mem[A + reg[R]]; mode code 9 (postindexed) returns mem[A] + reg[R]; each costs exactly one memory read.
- R8: A read request stays high with an unchanged address until the cycle in which mem_rvalid is seen.
- R9: done is a single-cycle pulse; it rises two cycles after the start edge for modes without memory reads, and one cycle after the last read response otherwise.
- R10: start is ignored while a request is in progress; the result and the read count of that request are unaffected.
- R11: After reset done, mem_req and rf_we are low, and result and mem_count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a request; sampled only when idle |
| mode | input | 4 | Addressing mode code |
| addr_a | input | AW | Address field A |
| reg_sel | input | RIW | Register index R |
| pc | input | AW | Current program counter |
| depth_m1 | input | DW | Indirection depth minus one |
| rf_sel | output | RIW | Register file read and write index |
| rf_rdata | input | AW | Register file read data (combinational) |
| rf_we | output | 1 | Register write-back enable |
| rf_wdata | output | AW | Register write-back data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_rvalid | input | 1 | Memory read response valid |
| mem_rdata | input | AW | Memory read data |
| done | output | 1 | Request complete pulse |
| result | output | AW | Effective address or operand |
| mem_count | output | CW | Memory reads issued for the current request |

## Verification
Counting negative edges from the start edge, done appears at the second one for register and arithmetic modes, and with a prompt memory (response one cycle after a request is seen, then one idle cycle) at 2 + 2n for a request costing n reads. The bench polls done at the negative edge, records that count and compares it with this formula for every request on the prompt memory; on runs with random memory stalls it only checks values and counts, while a monitor at each negative edge checks that a waiting request keeps its address. The written-back register is read again through mode 3 on a following request.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [3:0] {
    AM_IMM   = 4'd0,
    AM_DIR   = 4'd1,
    AM_IND   = 4'd2,
    AM_REG   = 4'd3,
    AM_RIND  = 4'd4,
    AM_DISP  = 4'd5,
    AM_PCREL = 4'd6,
    AM_IDX   = 4'd7,
    AM_PRE   = 4'd8,
    AM_POST  = 4'd9
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_WALK = 2'd2,
    ST_FIN  = 2'd3
  } ea_state_e;

  // Modes whose result comes from the read port.
  function automatic logic mode_walks(input amode_e m);
    return (m == AM_IND) || (m == AM_PRE) || (m == AM_POST);
  endfunction

endpackage

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 2
) (
  input  amode_e          mode_i,
  input  logic [AW-1:0]   a_i,
  input  logic [AW-1:0]   pc_i,
  input  logic [AW-1:0]   rval_i,
  input  logic [DW-1:0]   depth_m1_i,
  output logic            walk_o,
  output logic [AW-1:0]   ptr_o,
  output logic [DW-1:0]   levels_m1_o,
  output logic            post_add_o,
  output logic [AW-1:0]   res_o,
  output logic            wb_o,
  output logic [AW-1:0]   wb_val_o
);

  // Modular address addition, kept apart so that every adder shares it.
  function automatic logic [AW-1:0] add_wrap(input logic [AW-1:0] x,
                                             input logic [AW-1:0] y);
    return x + y;
  endfunction

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] x);
    return x + AW'(1);
  endfunction

  always_comb begin
    walk_o      = mode_walks(mode_i);
    ptr_o       = a_i;
    levels_m1_o = '0;
    post_add_o  = 1'b0;
    res_o       = a_i;
    wb_o        = 1'b0;
    wb_val_o    = bump(rval_i);
    unique case (mode_i)
      AM_IND:   levels_m1_o = depth_m1_i;
      AM_REG,
      AM_RIND:  res_o = rval_i;
      AM_DISP:  res_o = add_wrap(a_i, rval_i);
      AM_PCREL: res_o = add_wrap(a_i, pc_i);
      AM_IDX: begin
        res_o = add_wrap(a_i, rval_i);
        wb_o  = 1'b1;
      end
      AM_PRE:   ptr_o = add_wrap(a_i, rval_i);
      AM_POST:  post_add_o = 1'b1;
      default:  res_o = a_i;
    endcase
  end

endmodule

// File: rtl/ea_walker.sv
module ea_walker #(
  parameter int AW   = 16,
  parameter int DW   = 2,
  parameter int CW   = 3,
  parameter int MAXD = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            launch_i,
  input  logic [AW-1:0]   ptr_i,
  input  logic [DW-1:0]   levels_m1_i,
  input  logic            post_add_i,
  input  logic [AW-1:0]   index_i,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [AW-1:0]   mem_rdata_i,
  output logic            fin_o,
  output logic [AW-1:0]   fin_val_o,
  output logic [CW-1:0]   count_o
);

  logic            busy_q;
  logic [AW-1:0]   ptr_q;
  logic [DW-1:0]   left_q;
  logic            post_q;
  logic [AW-1:0]   idx_q;
  logic [CW-1:0]   count_q;

  // Named events for the checks below.
  logic rsp_take;
  logic last_level;

  assign rsp_take   = busy_q && mem_rvalid_i;
  assign last_level = (left_q == '0);
  assign fin_o      = rsp_take && last_level;
  assign fin_val_o  = post_q ? (mem_rdata_i + idx_q) : mem_rdata_i;

  assign mem_req_o  = busy_q;
  assign mem_addr_o = ptr_q;
  assign count_o    = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ptr_q   <= '0;
      left_q  <= '0;
      post_q  <= 1'b0;
      idx_q   <= '0;
      count_q <= '0;
    end else begin
      if (clear_i) begin
        count_q <= '0;
      end
      if (launch_i) begin
        busy_q <= 1'b1;
        ptr_q  <= ptr_i;
        left_q <= levels_m1_i;
        post_q <= post_add_i;
        idx_q  <= index_i;
      end else if (rsp_take) begin
        count_q <= count_q + CW'(1);
        if (last_level) begin
          busy_q <= 1'b0;
        end else begin
          ptr_q  <= mem_rdata_i;
          left_q <= left_q - DW'(1);
        end
      end
    end
  end

  // R8: a waiting request keeps its address.
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R3: never more reads than the deepest chain.
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(MAXD));

  // R3: a response on an inner level leads to the next read.
  p_chain_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && !last_level) |=> (mem_req_o && mem_addr_o == $past(mem_rdata_i)));

endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 8,
  parameter int MAXD = 4,
  localparam int RIW = $clog2(NREG),
  localparam int DW  = (MAXD > 1) ? $clog2(MAXD) : 1,
  localparam int CW  = $clog2(MAXD + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      mode,
  input  logic [AW-1:0]   addr_a,
  input  logic [RIW-1:0]  reg_sel,
  input  logic [AW-1:0]   pc,
  input  logic [DW-1:0]   depth_m1,
  output logic [RIW-1:0]  rf_sel,
  input  logic [AW-1:0]   rf_rdata,
  output logic            rf_we,
  output logic [AW-1:0]   rf_wdata,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_rvalid,
  input  logic [AW-1:0]   mem_rdata,
  output logic            done,
  output logic [AW-1:0]   result,
  output logic [CW-1:0]   mem_count
);

  ea_state_e      state_q;
  amode_e         mode_q;
  logic [AW-1:0]  a_q;
  logic [AW-1:0]  pc_q;
  logic [RIW-1:0] r_q;
  logic [DW-1:0]  depth_q;
  logic [AW-1:0]  result_q;

  // Named events.
  logic accept;
  logic in_calc;
  logic launch;
  logic walk_fin;

  logic            c_walk;
  logic [AW-1:0]   c_ptr;
  logic [DW-1:0]   c_lev;
  logic            c_post;
  logic [AW-1:0]   c_res;
  logic            c_wb;
  logic [AW-1:0]   c_wbv;
  logic [AW-1:0]   w_val;

  assign accept  = (state_q == ST_IDLE) && start;
  assign in_calc = (state_q == ST_CALC);
  assign launch  = in_calc && c_walk;

  ea_calc #(.AW(AW), .DW(DW)) i_calc (
    .mode_i      (mode_q),
    .a_i         (a_q),
    .pc_i        (pc_q),
    .rval_i      (rf_rdata),
    .depth_m1_i  (depth_q),
    .walk_o      (c_walk),
    .ptr_o       (c_ptr),
    .levels_m1_o (c_lev),
    .post_add_o  (c_post),
    .res_o       (c_res),
    .wb_o        (c_wb),
    .wb_val_o    (c_wbv)
  );

  ea_walker #(.AW(AW), .DW(DW), .CW(CW), .MAXD(MAXD)) i_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (accept),
    .launch_i     (launch),
    .ptr_i        (c_ptr),
    .levels_m1_i  (c_lev),
    .post_add_i   (c_post),
    .index_i      (rf_rdata),
    .mem_req_o    (mem_req),
    .mem_addr_o   (mem_addr),
    .mem_rvalid_i (mem_rvalid),
    .mem_rdata_i  (mem_rdata),
    .fin_o        (walk_fin),
    .fin_val_o    (w_val),
    .count_o      (mem_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= AM_IMM;
      a_q      <= '0;
      pc_q     <= '0;
      r_q      <= '0;
      depth_q  <= '0;
      result_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          mode_q  <= amode_e'(mode);
          a_q     <= addr_a;
          pc_q    <= pc;
          r_q     <= reg_sel;
          depth_q <= depth_m1;
          state_q <= ST_CALC;
        end
        ST_CALC: begin
          if (c_walk) begin
            state_q <= ST_WALK;
          end else begin
            result_q <= c_res;
            state_q  <= ST_FIN;
          end
        end
        ST_WALK: if (walk_fin) begin
          result_q <= w_val;
          state_q  <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rf_sel   = r_q;
  assign rf_we    = in_calc && c_wb;
  assign rf_wdata = c_wbv;
  assign done     = (state_q == ST_FIN);
  assign result   = result_q;

  // R9: done lasts one cycle.
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: the last response is followed by done.
  p_last_then_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    walk_fin |=> done);

  // R6: only the indexed mode writes the register file.
  p_wb_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mode_q == AM_IDX));

  // R1: immediate mode costs no read.
  p_no_read_imm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == AM_IMM) |-> (mem_count == '0));

  // R10: no read is outstanding while idle.
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !mem_req);

endmodule

// File: tb/test_ea_unit.sv
module test_ea_unit;

  localparam int AW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] addr_a = '0;
  logic [2:0]  reg_sel = '0;
  logic [15:0] pc = '0;
  logic [1:0]  depth_m1 = '0;
  logic [2:0]  rf_sel;
  logic [15:0] rf_rdata;
  logic        rf_we;
  logic [15:0] rf_wdata;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid;
  logic [15:0] mem_rdata;
  logic        done;
  logic [15:0] result;
  logic [2:0]  mem_count;

  int checks = 0;
  int failures = 0;
  logic stall_en = 1'b0;
  int hold_err = 0;

  always #2 clk = ~clk;

  ea_unit #(.AW(AW), .NREG(8), .MAXD(4)) i_ea_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .addr_a(addr_a),
    .reg_sel(reg_sel), .pc(pc), .depth_m1(depth_m1), .rf_sel(rf_sel),
    .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .done(done), .result(result), .mem_count(mem_count)
  );

  function automatic logic [15:0] memf(input logic [15:0] ad);
    return (ad * 16'h9E37) ^ 16'h5A5A ^ {ad[7:0], ad[15:8]};
  endfunction

  function automatic logic [15:0] rinit(input int i);
    return (i == 7) ? 16'hFFFF : 16'(i * 16'h1111 + 16'h00F3);
  endfunction

  // Environment: register file and memory with one-cycle response.
  logic [15:0] regs [8];
  logic [15:0] exp_regs [8];
  assign rf_rdata = regs[rf_sel];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) regs[i] <= rinit(i);
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      if (rf_we) regs[rf_sel] <= rf_wdata;
      mem_rvalid <= mem_req && !mem_rvalid && (!stall_en || ($urandom % 3 == 0));
      mem_rdata  <= memf(mem_addr);
    end
  end

  // R8 monitor: waiting request keeps its address.
  logic        w_prev = 1'b0;
  logic [15:0] a_prev = '0;
  always @(negedge clk) begin
    if (rst_n && w_prev && (!mem_req || mem_addr != a_prev)) hold_err++;
    w_prev = mem_req && !mem_rvalid;
    a_prev = mem_addr;
  end

  // Expected values from the requirements.
  function automatic logic [15:0] exp_val(input logic [3:0] m, input logic [15:0] a,
                                          input logic [2:0] r, input logic [15:0] p,
                                          input logic [1:0] d);
    logic [15:0] v;
    case (m)
      4'd0, 4'd1: v = a;
      4'd2: begin
        v = a;
        for (int i = 0; i <= int'(d); i++) v = memf(v);
      end
      4'd3, 4'd4: v = exp_regs[r];
      4'd5, 4'd7: v = a + exp_regs[r];
      4'd6: v = a + p;
      4'd8: v = memf(a + exp_regs[r]);
      4'd9: v = memf(a) + exp_regs[r];
      default: v = a;
    endcase
    return v;
  endfunction

  function automatic int exp_reads(input logic [3:0] m, input logic [1:0] d);
    if (m == 4'd2) return int'(d) + 1;
    if (m == 4'd8 || m == 4'd9) return 1;
    return 0;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int lat;
  logic done_after;

  task automatic run_op(input logic [3:0] m, input logic [15:0] a, input logic [2:0] r,
                        input logic [15:0] p, input logic [1:0] d, input logic poke);
    @(negedge clk);
    mode = m; addr_a = a; reg_sel = r; pc = p; depth_m1 = d; start = 1'b1;
    lat = 0;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    mode = 4'd0; addr_a = 16'hDEAD; reg_sel = 3'd0; depth_m1 = 2'd0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
      start = poke && (lat == 3);
    end
    start = 1'b0;
    @(negedge clk);
    done_after = done;
  endtask

  task automatic full_op(input logic [3:0] m, input logic [15:0] a, input logic [2:0] r,
                         input logic [15:0] p, input logic [1:0] d, input string tag,
                         input logic chk_lat);
    logic [15:0] ev;
    int er;
    ev = exp_val(m, a, r, p, d);
    er = exp_reads(m, d);
    run_op(m, a, r, p, d, 1'b0);
    if (m == 4'd7) exp_regs[r] = exp_regs[r] + 16'd1;
    chk(result == ev, tag, 32'(result), 32'(ev));
    chk(int'(mem_count) == er, tag, 32'(mem_count), 32'(er));
    if (chk_lat) chk(lat == 2 + 2 * er, {tag, " R9 latency"}, 32'(lat), 32'(2 + 2 * er));
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) exp_regs[i] = rinit(i);
    #9;
    // R11 reset state
    chk(!done && !mem_req && !rf_we, "R11 reset controls", {29'd0, done, mem_req, rf_we}, 0);
    chk(result == 0 && mem_count == 0, "R11 reset values", {13'd0, mem_count, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    full_op(4'd0, 16'h1234, 3'd1, 16'h0, 2'd3, "R1 immediate", 1'b1);
    full_op(4'd1, 16'hBEEF, 3'd2, 16'h0, 2'd0, "R2 direct", 1'b1);
    full_op(4'd12, 16'h0F0F, 3'd2, 16'h0, 2'd2, "R2 reserved code", 1'b1);
    full_op(4'd15, 16'hA5A5, 3'd2, 16'h0, 2'd1, "R2 reserved code", 1'b1);
    for (int d = 0; d < 4; d++) full_op(4'd2, 16'h0100, 3'd0, 16'h0, 2'(d), "R3 indirect", 1'b1);
    full_op(4'd3, 16'h0000, 3'd3, 16'h0, 2'd0, "R4 register", 1'b1);
    full_op(4'd4, 16'h7777, 3'd5, 16'h0, 2'd0, "R4 register-indirect", 1'b1);
    full_op(4'd5, 16'hF000, 3'd6, 16'h0, 2'd0, "R5 displacement wrap", 1'b1);
    full_op(4'd6, 16'hFFF0, 3'd0, 16'h0020, 2'd0, "R5 pc-relative wrap", 1'b1);
    full_op(4'd7, 16'h0010, 3'd7, 16'h0, 2'd0, "R6 indexed", 1'b1);
    full_op(4'd3, 16'h0000, 3'd7, 16'h0, 2'd0, "R6 write-back wrapped", 1'b1);
    full_op(4'd7, 16'h0002, 3'd7, 16'h0, 2'd0, "R6 indexed again", 1'b1);
    full_op(4'd5, 16'h0000, 3'd7, 16'h0, 2'd0, "R6 write-back seen", 1'b1);
    full_op(4'd5, 16'h0000, 3'd1, 16'h0, 2'd0, "R6 other reg untouched", 1'b1);
    full_op(4'd8, 16'h0040, 3'd2, 16'h0, 2'd3, "R7 preindexed", 1'b1);
    full_op(4'd9, 16'h0040, 3'd2, 16'h0, 2'd3, "R7 postindexed", 1'b1);

    // R9 pulse width
    run_op(4'd2, 16'h0333, 3'd0, 16'h0, 2'd1, 1'b0);
    chk(!done_after, "R9 done one cycle", 32'(done_after), 0);

    // R10 start while busy
    run_op(4'd2, 16'h0555, 3'd0, 16'h0, 2'd3, 1'b1);
    chk(result == exp_val(4'd2, 16'h0555, 3'd0, 16'h0, 2'd3), "R10 result kept",
        32'(result), 32'(exp_val(4'd2, 16'h0555, 3'd0, 16'h0, 2'd3)));
    chk(mem_count == 3'd4 && lat == 10, "R10 count and timing", {16'(lat), 13'd0, mem_count}, 32'h000A0004);
    @(negedge clk);
    chk(!done && !mem_req, "R10 no extra request", {30'd0, done, mem_req}, 0);

    // Random with prompt memory
    for (int k = 0; k < 300; k++) begin
      full_op(4'($urandom % 16), 16'($urandom), 3'($urandom), 16'($urandom),
              2'($urandom), "R3 R7 random", 1'b1);
    end

    // R8 stalled memory
    stall_en = 1'b1;
    for (int k = 0; k < 80; k++) begin
      full_op(4'($urandom % 16), 16'($urandom), 3'($urandom), 16'($urandom),
              2'($urandom), "R8 stalled", 1'b0);
    end
    stall_en = 1'b0;
    chk(hold_err == 0, "R8 request held", 32'(hold_err), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule